// File: doc/BRIEF.md
# Vector element register sequencer

This block takes one instruction written in vector form and turns it into a run of scalar element operations, issuing one per cycle. All operands live in one unified register index space of 128 entries, addressed with 7 bits. Integer register names map onto indices 0 to 31, and index 0 is the constant-zero register. Floating-point name N maps onto index 32+N. Indices 64 to 127 can only be reached when a vector run walks past index 63.

Each operand carries its own vector flag. A vector operand advances by one index on every element. A scalar operand keeps the same index on every element. Because the two register classes share the space, a vector run can cross from the integer range straight into the floating-point range.

The downstream side sees, for each element:
- the opcode;
- the destination, three source and predicate indices;
- an element number;
- first and last markers;
- a write enable;
- an error flag.

Both sides use ready/valid handshakes. The block produces only the index sequence. Register file access, execution and predicate evaluation are left to other blocks.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: When `in_fp` is 0, a register name N on rd, rs1, rs2 or rs3 maps to index N. When `in_fp` is 1, it maps to index 32+N. The predicate name always maps to index N, ignoring `in_fp`.
- R3: A vector operand on element k carries index base+k. The run is contiguous across index 31/32: integer base 30 with length 4 gives 30, 31, 32, 33.
- R4: A scalar operand (vector flag 0), the predicate and the opcode are identical on every element of a run.
- R5: `out_elem` counts 0 to VL-1 in order. `out_first` is 1 only on element 0, and `out_last` is 1 only on element VL-1.
- R6: A length of 0 is accepted, emits no element, and leaves `in_ready` at 1 in the next cycle. A length of 1 emits a single element with both `out_first` and `out_last` set.
- R7: If any vector operand's base+k exceeds 127 on an element, that element has `out_err`=1 and `out_wen`=0. Each overflowing index field reads 0; it does not wrap.
- R8: `out_wen` is 0 whenever the destination index is 0. Otherwise it is 1 unless R7 applies.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value into the next cycle.
- R10: After an instruction with nonzero length is accepted, `in_ready` is 0 until the cycle after its last element is handed off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| in_op | input | OPW | Opcode |
| in_fp | input | 1 | Class of rd/rs1/rs2/rs3: 0 integer, 1 floating point |
| in_vl | input | VLW | Vector length |
| in_rd | input | 5 | Destination name |
| in_rs1 | input | 5 | Source 1 name |
| in_rs2 | input | 5 | Source 2 name |
| in_rs3 | input | 5 | Source 3 name |
| in_pred | input | 5 | Predicate name (integer class) |
| in_vec | input | 4 | Vector flags: bit0 rd, bit1 rs1, bit2 rs2, bit3 rs3 |
| out_valid | output | 1 | Element offered |
| out_ready | input | 1 | Element can be taken |
| out_op | output | OPW | Opcode |
| out_rd | output | 7 | Destination index (old value read for merge) |
| out_rs1 | output | 7 | Source 1 index |
| out_rs2 | output | 7 | Source 2 index |
| out_rs3 | output | 7 | Source 3 index |
| out_pred | output | 7 | Predicate index |
| out_elem | output | VLW | Element number |
| out_first | output | 1 | First element of run |
| out_last | output | 1 | Last element of run |
| out_wen | output | 1 | Destination write allowed |
| out_err | output | 1 | Index overflow on this element |

## Verification
The bench aims at four corner cases:
- Integer-to-floating-point crossing at index 31/32: a design that reset or wrapped its count per class would emit 0 or 30 where 32 is due.
- A floating-point vector run starting at index 63 that reaches 127 and then overflows: a wrapping design would show small indices with `out_err` low.
- Zero and one element lengths: an off-by-one last test would emit a stray element, or hang with `in_ready` low.
- Random output stalls: a design that advanced without a handshake would skip element numbers or change fields mid-stall.

A destination of index 0 is also issued to catch a design that lets writes reach the zero register.

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int OPW = 4,
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] in_op,
  input  logic           in_fp,
  input  logic [VLW-1:0] in_vl,
  input  logic [4:0]     in_rd,
  input  logic [4:0]     in_rs1,
  input  logic [4:0]     in_rs2,
  input  logic [4:0]     in_rs3,
  input  logic [4:0]     in_pred,
  input  logic [3:0]     in_vec,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [OPW-1:0] out_op,
  output logic [6:0]     out_rd,
  output logic [6:0]     out_rs1,
  output logic [6:0]     out_rs2,
  output logic [6:0]     out_rs3,
  output logic [6:0]     out_pred,
  output logic [VLW-1:0] out_elem,
  output logic           out_first,
  output logic           out_last,
  output logic           out_wen,
  output logic           out_err
);
  localparam int IW = 7;
  localparam int SW = (IW > VLW ? IW : VLW) + 1;
  localparam logic [IW-1:0] FP_OFS = IW'(32);

  logic           busy;
  logic [OPW-1:0] op_q;
  logic [IW-1:0]  base_q [4];
  logic [IW-1:0]  pred_q;
  logic [3:0]     vec_q;
  logic [VLW-1:0] vl_q, elem_q;
  logic [IW-1:0]  idx [4];
  logic [3:0]     ovf;

  wire take = in_valid && in_ready;
  wire give = out_valid && out_ready;
  wire [IW-1:0] cls = in_fp ? FP_OFS : '0;

  assign in_ready  = !busy;
  assign out_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      elem_q <= '0;
      vl_q   <= '0;
    end else if (take) begin
      busy      <= (in_vl != '0);
      elem_q    <= '0;
      vl_q      <= in_vl;
      op_q      <= in_op;
      vec_q     <= in_vec;
      base_q[0] <= IW'(in_rd)  + cls;
      base_q[1] <= IW'(in_rs1) + cls;
      base_q[2] <= IW'(in_rs2) + cls;
      base_q[3] <= IW'(in_rs3) + cls;
      pred_q    <= IW'(in_pred);
    end else if (give) begin
      if (out_last) busy <= 1'b0;
      else elem_q <= elem_q + 1'b1;
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_op
    wire [SW-1:0] sum = SW'(base_q[g]) + (vec_q[g] ? SW'(elem_q) : '0);
    assign ovf[g] = sum > SW'(2**IW - 1);
    assign idx[g] = ovf[g] ? '0 : sum[IW-1:0];
  end

  assign out_op    = op_q;
  assign out_rd    = idx[0];
  assign out_rs1   = idx[1];
  assign out_rs2   = idx[2];
  assign out_rs3   = idx[3];
  assign out_pred  = pred_q;
  assign out_elem  = elem_q;
  assign out_first = busy && (elem_q == '0);
  assign out_last  = busy && (elem_q == vl_q - 1'b1);
  assign out_err   = busy && (|ovf);
  assign out_wen   = busy && !(|ovf) && (idx[0] != '0);

  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(!rst_n) |-> !out_valid && in_ready);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rd) && $stable(out_rs1) &&
      $stable(out_rs2) && $stable(out_rs3) && $stable(out_elem) && $stable(out_pred));
  // R5
  elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_elem == VLW'($past(out_elem) + 1'b1));
  // R10
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);
  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_vl == '0 |=> in_ready && !out_valid);
  // R5
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_vl != '0 |=> out_valid && out_first && !in_ready);
  // R8
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> out_rd != '0 && !out_err);
endmodule

// File: tb/sim_vec_elem_seq.sv
module sim_vec_elem_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] op;
    logic [6:0] rd, rs1, rs2, rs3, pred;
    logic [6:0] elem;
    logic first, last, wen, err;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_fp = 0;
  logic [3:0] in_op = 0, in_vec = 0;
  logic [6:0] in_vl = 0;
  logic [4:0] in_rd = 0, in_rs1 = 0, in_rs2 = 0, in_rs3 = 0, in_pred = 0;
  logic in_ready, out_valid, out_ready;
  logic [3:0] out_op;
  logic [6:0] out_rd, out_rs1, out_rs2, out_rs3, out_pred, out_elem;
  logic out_first, out_last, out_wen, out_err;
  logic bp_en = 0;
  logic [2:0] rcnt = 0;
  int errors = 0, checks = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) rcnt <= rcnt + 3'd1;
  assign out_ready = bp_en ? (rcnt != 3'd2 && rcnt != 3'd5 && rcnt != 3'd6) : 1'b1;

  vec_elem_seq u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_fp(in_fp), .in_vl(in_vl), .in_rd(in_rd), .in_rs1(in_rs1),
    .in_rs2(in_rs2), .in_rs3(in_rs3), .in_pred(in_pred), .in_vec(in_vec),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op), .out_rd(out_rd),
    .out_rs1(out_rs1), .out_rs2(out_rs2), .out_rs3(out_rs3), .out_pred(out_pred),
    .out_elem(out_elem), .out_first(out_first), .out_last(out_last),
    .out_wen(out_wen), .out_err(out_err));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] map_idx(input logic [4:0] n, input logic fp, input logic v, input int k);
    int s;
    s = (fp ? 32 : 0) + n + (v ? k : 0);
    return (s > 127) ? 8'h80 : 8'(s);
  endfunction

  task automatic send(input logic [3:0] op, input logic fp, input logic [6:0] vl,
                      input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2,
                      input logic [4:0] r3, input logic [4:0] pr, input logic [3:0] vec);
    for (int k = 0; k < vl; k++) begin
      exp_t e;
      logic [7:0] a, b, c, d;
      a = map_idx(rd, fp, vec[0], k);
      b = map_idx(r1, fp, vec[1], k);
      c = map_idx(r2, fp, vec[2], k);
      d = map_idx(r3, fp, vec[3], k);
      e.op = op; e.pred = 7'(pr);
      e.rd = a[6:0]; e.rs1 = b[6:0]; e.rs2 = c[6:0]; e.rs3 = d[6:0];
      e.err = a[7] | b[7] | c[7] | d[7];
      e.elem = 7'(k); e.first = (k == 0); e.last = (k == vl - 1);
      e.wen = !e.err && (e.rd != 0);
      q.push_back(e);
    end
    @(negedge clk);
    in_op = op; in_fp = fp; in_vl = vl; in_rd = rd; in_rs1 = r1; in_rs2 = r2;
    in_rs3 = r3; in_pred = pr; in_vec = vec; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    if (vl == 0) chk("R6", "ready after zero length", 64'(in_ready), 64'd1);
    else chk("R10", "ready low during run", 64'(in_ready), 64'd0);
  endtask

  exp_t held;
  bit stalled = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stalled && out_valid) begin
        exp_t cur;
        cur = '{out_op, out_rd, out_rs1, out_rs2, out_rs3, out_pred, out_elem,
                out_first, out_last, out_wen, out_err};
        chk("R9", "fields held in stall", 64'(cur), 64'(held));
      end
      stalled = out_valid && !out_ready;
      if (stalled)
        held = '{out_op, out_rd, out_rs1, out_rs2, out_rs3, out_pred, out_elem,
                 out_first, out_last, out_wen, out_err};
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk("R6", "unexpected element", 64'(out_elem), 64'h7f_dead);
        else begin
          exp_t e;
          e = q.pop_front();
          chk("R2/R3/R7", "rd", 64'(out_rd), 64'(e.rd));
          chk("R3/R4", "rs1", 64'(out_rs1), 64'(e.rs1));
          chk("R3/R4", "rs2", 64'(out_rs2), 64'(e.rs2));
          chk("R3/R4", "rs3", 64'(out_rs3), 64'(e.rs3));
          chk("R2/R4", "pred/op", 64'({out_pred, out_op}), 64'({e.pred, e.op}));
          chk("R5", "elem/first/last", 64'({out_elem, out_first, out_last}),
              64'({e.elem, e.first, e.last}));
          chk("R7/R8", "wen/err", 64'({out_wen, out_err}), 64'({e.wen, e.err}));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid/ready in reset", 64'({out_valid, in_ready}), 64'b01);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "valid/ready after reset", 64'({out_valid, in_ready}), 64'b01);
    // R2 integer scalar, length 1 (R6)
    send(4'h1, 0, 7'd1, 5'd5, 5'd7, 5'd0, 5'd31, 5'd3, 4'b0000);
    // R2 floating point scalar
    send(4'h2, 1, 7'd1, 5'd2, 5'd0, 5'd31, 5'd9, 5'd4, 4'b0000);
    // R3 boundary crossing 30..33, rs3 scalar (R4)
    send(4'h3, 0, 7'd4, 5'd30, 5'd30, 5'd30, 5'd9, 5'd1, 4'b0111);
    // R6 zero length
    send(4'h4, 0, 7'd0, 5'd1, 5'd1, 5'd1, 5'd1, 5'd1, 4'b1111);
    // R9 stalls on an FP vector run
    bp_en = 1;
    send(4'h5, 1, 7'd8, 5'd4, 5'd10, 5'd20, 5'd6, 5'd2, 4'b1011);
    // R7 overflow: f31 vector reaches 127 then overflows
    send(4'h6, 1, 7'd70, 5'd0, 5'd31, 5'd1, 5'd1, 5'd7, 4'b0011);
    bp_en = 0;
    // R8 destination index 0 never written
    send(4'h7, 0, 7'd3, 5'd0, 5'd1, 5'd2, 5'd3, 5'd0, 4'b0110);
    // R10 back to back
    send(4'h8, 0, 7'd5, 5'd12, 5'd13, 5'd14, 5'd15, 5'd8, 4'b1111);
    send(4'h9, 1, 7'd2, 5'd30, 5'd31, 5'd0, 5'd1, 5'd9, 4'b0001);
    for (int i = 0; i < 400 && q.size() != 0; i++) @(negedge clk);
    chk("R5", "all expected elements seen", 64'(q.size()), 64'd0);
    repeat (2) @(negedge clk);
    chk("R10", "idle at end", 64'({out_valid, in_ready}), 64'b01);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule